// File: doc/BRIEF.md
# Dual-Bank Processor Register File

This block holds the programmer-visible registers of an 8-bit processor core. Six general-purpose byte registers (G0 to G5) and an accumulator/flag pair (ACC, FLG) each exist twice, as a main copy and an alternate copy. Two independent bank-select bits choose which copy is visible. An exchange strobe flips one of these bits. Because no data moves, a swap takes effect from the next cycle. Alongside the banked storage sit a stack pointer, two index registers (X0, X1) and an interrupt page byte (IPG). None of these four is banked.

The block has two combinational read ports and one synchronous write port. Each port has its own byte/word select. In byte mode the 4-bit address picks a single 8-bit register, and the read result is zero-extended to 16 bits. In word mode the address picks either a fixed pair or one of the 16-bit registers. Instruction decode, arithmetic and bus sequencing sit outside the block and drive these ports.

Top module: `banked_regfile`

## Requirements
- R1: In byte mode (word select 0) addresses 0 to 5 select G0 to G5 of the active general bank, 6 selects ACC and 7 selects FLG of the active accumulator bank. Both read ports return the selected byte combinationally in bits 7:0 with bits 15:8 zero.
- R2: In word mode address 0 is G0:G1, 1 is G2:G3, 2 is G4:G5 and 3 is ACC:FLG. The first-named register is bits 15:8 and the second is bits 7:0, for both reads and writes.
- R3: A write takes effect at the clock edge. A read of the same register in the write cycle returns the old value, and the next cycle returns the new one.
- R4: A pulse on `xchg_gp` switches the visible general bank from the next cycle. The contents of both banks are kept, so a second pulse shows the earlier values again.
- R5: `xchg_af` switches only the accumulator/flag bank, and `xchg_gp` switches only the general bank.
- R6: A write issued in the same cycle as an exchange lands in the bank that was active before the exchange.
- R7: Word addresses 4, 5 and 6 select the stack pointer, X0 and X1. These registers are shared by both banks and are not affected by exchanges.
- R8: Byte address 8 selects the interrupt page register IPG. It is shared by both banks.
- R9: Reset selects the main bank for both groups and sets the stack pointer to 16'hFFFF. All other register contents are not cleared by reset.
- R10: Byte addresses 9 to 15 and word addresses 7 to 15 read as zero. Writes to these addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_word | input | 1 | Read port A: 1 selects word mode, 0 selects byte mode |
| rd_a_addr | input | 4 | Read port A register address |
| rd_a_data | output | 16 | Read port A data |
| rd_b_word | input | 1 | Read port B: 1 selects word mode, 0 selects byte mode |
| rd_b_addr | input | 4 | Read port B register address |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_word | input | 1 | Write port: 1 selects word mode, 0 selects byte mode |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| xchg_gp | input | 1 | Exchange strobe for the general-purpose bank |
| xchg_af | input | 1 | Exchange strobe for the accumulator/flag bank |

## Verification
A bank-select bit in the wrong state shows up in the cycle right after the faulty edge. Every byte and pair read of that group then returns the other bank's values, while the unbanked registers stay correct. Writes that land in the wrong bank or the wrong pair half stay hidden until a later read, so the stimulus mixes exchanges and writes within the same cycle and then reads the register back through both banks. A stack pointer that resets wrong is visible on the first word read at address 4 after reset.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 4;
  localparam int NUM_GP = 6;
  localparam int NUM_AF = 2;
  localparam int NUM_PAIRS = NUM_GP / 2;

  // byte-mode addresses
  localparam logic [ADDR_W-1:0] BA_ACC = ADDR_W'(NUM_GP);
  localparam logic [ADDR_W-1:0] BA_FLG = ADDR_W'(NUM_GP + 1);
  localparam logic [ADDR_W-1:0] BA_IPG = ADDR_W'(NUM_GP + 2);

  // word-mode addresses
  localparam logic [ADDR_W-1:0] WA_AF = ADDR_W'(NUM_PAIRS);
  localparam logic [ADDR_W-1:0] WA_SP = ADDR_W'(NUM_PAIRS + 1);
  localparam logic [ADDR_W-1:0] WA_X0 = ADDR_W'(NUM_PAIRS + 2);
  localparam logic [ADDR_W-1:0] WA_X1 = ADDR_W'(NUM_PAIRS + 3);

  localparam logic [WORD_W-1:0] SP_RESET = {WORD_W{1'b1}};
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_out = s2_q;
endmodule

// File: rtl/rf_bank_sel.sv
module rf_bank_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg_gp,
  input  logic xchg_af,
  output logic gp_sel,
  output logic af_sel
);
  logic gp_d, af_d, gp_q, af_q;

  always_comb begin
    gp_d = gp_q ^ xchg_gp;
    af_d = af_q ^ xchg_af;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q <= 1'b0;
      af_q <= 1'b0;
    end else begin
      gp_q <= gp_d;
      af_q <= af_d;
    end
  end

  assign gp_sel = gp_q;
  assign af_sel = af_q;

  a_r4_gp_flip: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_gp |=> (gp_sel != $past(gp_sel)));
  a_r5_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_gp |=> $stable(gp_sel));
  a_r5_af_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_af |=> $stable(af_sel));
endmodule

// File: rtl/rf_banked_store.sv
module rf_banked_store #(
  parameter int NREG = 6,
  parameter int W    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bank_sel,
  input  logic [NREG-1:0] we,
  input  logic [W-1:0] wdata [NREG],
  output logic [W-1:0] view  [NREG]
);
  logic [W-1:0] mem_q [2][NREG];
  logic [W-1:0] mem_d [2][NREG];

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < NREG; i++) begin
      if (we[i]) mem_d[bank_sel][i] = wdata[i];
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign view[g] = mem_q[bank_sel][g];

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> (mem_q[$past(bank_sel)][g] == $past(wdata[g])));
    a_r6_other_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> (mem_q[~$past(bank_sel)][g] == $past(mem_q[~bank_sel][g])));
    a_r4_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !we[g] |=> ($stable(mem_q[0][g]) && $stable(mem_q[1][g])));
  end
endmodule

// File: rtl/rf_shared_store.sv
module rf_shared_store
  import banked_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_we,
  input  logic              x0_we,
  input  logic              x1_we,
  input  logic              ipg_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] sp,
  output logic [WORD_W-1:0] x0,
  output logic [WORD_W-1:0] x1,
  output logic [BYTE_W-1:0] ipg
);
  logic [WORD_W-1:0] sp_q, sp_d, x0_q, x0_d, x1_q, x1_d;
  logic [BYTE_W-1:0] ipg_q, ipg_d;

  always_comb begin
    sp_d  = sp_we  ? wdata : sp_q;
    x0_d  = x0_we  ? wdata : x0_q;
    x1_d  = x1_we  ? wdata : x1_q;
    ipg_d = ipg_we ? wdata[BYTE_W-1:0] : ipg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_RESET;
    else        sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    x0_q  <= x0_d;
    x1_q  <= x1_d;
    ipg_q <= ipg_d;
  end

  assign sp  = sp_q;
  assign x0  = x0_q;
  assign x1  = x1_q;
  assign ipg = ipg_q;

  a_r9_sp_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sp_q == SP_RESET));
  a_r7_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_we |=> $stable(sp_q));
  a_r8_ipg_write: assert property (@(posedge clk) disable iff (!rst_n)
    ipg_we |=> (ipg_q == $past(wdata[BYTE_W-1:0])));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_a_word,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic              rd_b_word,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [WORD_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              xchg_gp,
  input  logic              xchg_af
);
  logic rst_n_s;
  logic gp_sel, af_sel;
  logic [NUM_GP-1:0] gp_we;
  logic [NUM_AF-1:0] af_we;
  logic [BYTE_W-1:0] gp_wd [NUM_GP];
  logic [BYTE_W-1:0] af_wd [NUM_AF];
  logic [BYTE_W-1:0] gp_view [NUM_GP];
  logic [BYTE_W-1:0] af_view [NUM_AF];
  logic sp_we, x0_we, x1_we, ipg_we;
  logic [WORD_W-1:0] sp, x0, x1;
  logic [BYTE_W-1:0] ipg;

  rf_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  rf_bank_sel u_sel (
    .clk(clk), .rst_n(rst_n_s), .xchg_gp(xchg_gp), .xchg_af(xchg_af),
    .gp_sel(gp_sel), .af_sel(af_sel)
  );

  // even index = high byte of a pair in word mode
  for (genvar g = 0; g < NUM_GP; g++) begin : g_gpwd
    if (g % 2 == 0) begin : g_hi
      assign gp_wd[g] = wr_word ? wr_data[WORD_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
    end else begin : g_lo
      assign gp_wd[g] = wr_data[BYTE_W-1:0];
    end
  end
  assign af_wd[0] = wr_word ? wr_data[WORD_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
  assign af_wd[1] = wr_data[BYTE_W-1:0];

  always_comb begin
    gp_we  = '0;
    af_we  = '0;
    sp_we  = 1'b0;
    x0_we  = 1'b0;
    x1_we  = 1'b0;
    ipg_we = 1'b0;
    if (wr_en) begin
      if (!wr_word) begin
        for (int k = 0; k < NUM_GP; k++) begin
          if (wr_addr == ADDR_W'(k)) gp_we[k] = 1'b1;
        end
        if (wr_addr == BA_ACC) af_we[0] = 1'b1;
        if (wr_addr == BA_FLG) af_we[1] = 1'b1;
        if (wr_addr == BA_IPG) ipg_we = 1'b1;
      end else begin
        for (int k = 0; k < NUM_PAIRS; k++) begin
          if (wr_addr == ADDR_W'(k)) begin
            gp_we[2*k]   = 1'b1;
            gp_we[2*k+1] = 1'b1;
          end
        end
        if (wr_addr == WA_AF) af_we = '1;
        if (wr_addr == WA_SP) sp_we = 1'b1;
        if (wr_addr == WA_X0) x0_we = 1'b1;
        if (wr_addr == WA_X1) x1_we = 1'b1;
      end
    end
  end

  rf_banked_store #(.NREG(NUM_GP), .W(BYTE_W)) u_gp (
    .clk(clk), .rst_n(rst_n_s), .bank_sel(gp_sel), .we(gp_we),
    .wdata(gp_wd), .view(gp_view)
  );

  rf_banked_store #(.NREG(NUM_AF), .W(BYTE_W)) u_af (
    .clk(clk), .rst_n(rst_n_s), .bank_sel(af_sel), .we(af_we),
    .wdata(af_wd), .view(af_view)
  );

  rf_shared_store u_shr (
    .clk(clk), .rst_n(rst_n_s), .sp_we(sp_we), .x0_we(x0_we), .x1_we(x1_we),
    .ipg_we(ipg_we), .wdata(wr_data), .sp(sp), .x0(x0), .x1(x1), .ipg(ipg)
  );

  // read ports
  logic              p_word [2];
  logic [ADDR_W-1:0] p_addr [2];
  logic [WORD_W-1:0] p_data [2];

  assign p_word[0] = rd_a_word;
  assign p_addr[0] = rd_a_addr;
  assign p_word[1] = rd_b_word;
  assign p_addr[1] = rd_b_addr;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      p_data[p] = '0;
      if (!p_word[p]) begin
        for (int k = 0; k < NUM_GP; k++) begin
          if (p_addr[p] == ADDR_W'(k)) p_data[p] = {{BYTE_W{1'b0}}, gp_view[k]};
        end
        if (p_addr[p] == BA_ACC) p_data[p] = {{BYTE_W{1'b0}}, af_view[0]};
        if (p_addr[p] == BA_FLG) p_data[p] = {{BYTE_W{1'b0}}, af_view[1]};
        if (p_addr[p] == BA_IPG) p_data[p] = {{BYTE_W{1'b0}}, ipg};
      end else begin
        for (int k = 0; k < NUM_PAIRS; k++) begin
          if (p_addr[p] == ADDR_W'(k)) p_data[p] = {gp_view[2*k], gp_view[2*k+1]};
        end
        if (p_addr[p] == WA_AF) p_data[p] = {af_view[0], af_view[1]};
        if (p_addr[p] == WA_SP) p_data[p] = sp;
        if (p_addr[p] == WA_X0) p_data[p] = x0;
        if (p_addr[p] == WA_X1) p_data[p] = x1;
      end
    end
  end

  assign rd_a_data = p_data[0];
  assign rd_b_data = p_data[1];

  a_r3_read_after_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !wr_word && (wr_addr <= BA_IPG) && !xchg_gp && !xchg_af) |=>
      ((!rd_a_word && (rd_a_addr == $past(wr_addr))) ->
        (rd_a_data == {{BYTE_W{1'b0}}, $past(wr_data[BYTE_W-1:0])})));
  a_r7_sp_exchange_free: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(wr_en && wr_word && (wr_addr == WA_SP)) && (xchg_gp || xchg_af)) |=> $stable(sp));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_a_word, rd_b_word, wr_en, wr_word, xchg_gp, xchg_af;
  logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [15:0] rd_a_data, rd_b_data, wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference state
  logic [7:0]  m_gp [2][6];
  logic [7:0]  m_af [2][2];
  logic [15:0] m_sp, m_x0, m_x1;
  logic [7:0]  m_ipg;
  bit          m_gsel, m_asel;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_word(rd_a_word), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_word(rd_b_word), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr), .wr_data(wr_data),
    .xchg_gp(xchg_gp), .xchg_af(xchg_af)
  );

  function automatic logic [15:0] exp_rd(input bit w, input logic [3:0] a);
    logic [15:0] r = 16'h0000;
    if (!w) begin
      if (a < 4'd6)       r = {8'h00, m_gp[m_gsel][a]};
      else if (a == 4'd6) r = {8'h00, m_af[m_asel][0]};
      else if (a == 4'd7) r = {8'h00, m_af[m_asel][1]};
      else if (a == 4'd8) r = {8'h00, m_ipg};
    end else begin
      case (a)
        4'd0: r = {m_gp[m_gsel][0], m_gp[m_gsel][1]};
        4'd1: r = {m_gp[m_gsel][2], m_gp[m_gsel][3]};
        4'd2: r = {m_gp[m_gsel][4], m_gp[m_gsel][5]};
        4'd3: r = {m_af[m_asel][0], m_af[m_asel][1]};
        4'd4: r = m_sp;
        4'd5: r = m_x0;
        4'd6: r = m_x1;
        default: r = 16'h0000;
      endcase
    end
    return r;
  endfunction

  task automatic model_update(input bit we, input bit w, input logic [3:0] a,
                              input logic [15:0] d, input bit xg, input bit xa);
    if (we) begin
      if (!w) begin
        if (a < 4'd6)       m_gp[m_gsel][a] = d[7:0];
        else if (a == 4'd6) m_af[m_asel][0] = d[7:0];
        else if (a == 4'd7) m_af[m_asel][1] = d[7:0];
        else if (a == 4'd8) m_ipg = d[7:0];
      end else begin
        case (a)
          4'd0, 4'd1, 4'd2: begin
            m_gp[m_gsel][2*a]   = d[15:8];
            m_gp[m_gsel][2*a+1] = d[7:0];
          end
          4'd3: begin
            m_af[m_asel][0] = d[15:8];
            m_af[m_asel][1] = d[7:0];
          end
          4'd4: m_sp = d;
          4'd5: m_x0 = d;
          4'd6: m_x1 = d;
          default: ;
        endcase
      end
    end
    if (xg) m_gsel = ~m_gsel;
    if (xa) m_asel = ~m_asel;
  endtask

  task automatic check(input string tag, input string port,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check reads, clock, update reference
  task automatic op(input string tag, input bit we, input bit w, input logic [3:0] wa,
                    input logic [15:0] wd, input bit xg, input bit xa,
                    input bit aw, input logic [3:0] aa, input bit bw, input logic [3:0] ba);
    wr_en = we; wr_word = w; wr_addr = wa; wr_data = wd;
    xchg_gp = xg; xchg_af = xa;
    rd_a_word = aw; rd_a_addr = aa; rd_b_word = bw; rd_b_addr = ba;
    #1;
    check(tag, "A", rd_a_data, exp_rd(aw, aa));
    check(tag, "B", rd_b_data, exp_rd(bw, ba));
    @(posedge clk);
    model_update(we, w, wa, wd, xg, xa);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; wr_word = 0; wr_addr = 0; wr_data = 0; xchg_gp = 0; xchg_af = 0;
    rd_a_word = 0; rd_a_addr = 0; rd_b_word = 0; rd_b_addr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_gsel = 0; m_asel = 0; m_sp = 16'hFFFF;
  endtask

  task automatic fill_bank(input string tag);
    for (int k = 0; k < 9; k++)
      op(tag, 1, 0, 4'(k), 16'($urandom), 0, 0, 0, 4'(k), 1, 4'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    rst_n = 1'b0;
    do_reset();

    // R9: stack pointer after reset
    op("R9", 0, 0, 0, 0, 0, 0, 1, 4'd4, 1, 4'd4);

    // initialise main banks, then alternate banks (R1)
    fill_bank("R1");
    op("R7", 1, 1, 4'd5, 16'hA5C3, 0, 0, 1, 4'd5, 1, 4'd6);
    op("R7", 1, 1, 4'd6, 16'h3C5A, 0, 0, 1, 4'd5, 1, 4'd6);
    op("R4", 0, 0, 0, 0, 1, 1, 0, 4'd0, 0, 4'd6);
    fill_bank("R1");
    op("R4", 0, 0, 0, 0, 1, 1, 0, 4'd0, 0, 4'd6);
    op("R4", 0, 0, 0, 0, 0, 0, 0, 4'd0, 1, 4'd3);

    // R2: pair ordering, write then read
    op("R2", 1, 1, 4'd1, 16'h1234, 0, 0, 1, 4'd1, 0, 4'd2);
    op("R2", 0, 0, 0, 0, 0, 0, 0, 4'd2, 0, 4'd3);
    op("R2", 1, 1, 4'd3, 16'hBEEF, 0, 0, 0, 4'd6, 0, 4'd7);
    op("R2", 0, 0, 0, 0, 0, 0, 0, 4'd6, 1, 4'd3);

    // R3: same-cycle read returns old value, next cycle the new one
    op("R3", 1, 0, 4'd4, 16'h005A, 0, 0, 0, 4'd4, 1, 4'd2);
    op("R3", 0, 0, 0, 0, 0, 0, 0, 4'd4, 1, 4'd2);

    // R6: write with exchange lands in the old bank
    op("R6", 1, 0, 4'd0, 16'h0077, 1, 0, 0, 4'd0, 0, 4'd1);
    op("R6", 0, 0, 0, 0, 0, 0, 0, 4'd0, 1, 4'd0);
    op("R6", 0, 0, 0, 0, 1, 0, 0, 4'd0, 1, 4'd0);
    op("R6", 0, 0, 0, 0, 0, 0, 0, 4'd0, 1, 4'd0);

    // R5: accumulator exchange leaves general bank alone
    op("R5", 0, 0, 0, 0, 0, 1, 0, 4'd6, 0, 4'd3);
    op("R5", 0, 0, 0, 0, 0, 0, 0, 4'd6, 0, 4'd3);
    op("R5", 0, 0, 0, 0, 0, 0, 1, 4'd3, 1, 4'd2);

    // R7 / R8: shared registers unaffected by exchanges
    op("R8", 1, 0, 4'd8, 16'h00C7, 1, 1, 0, 4'd8, 1, 4'd4);
    op("R7", 1, 1, 4'd4, 16'h8001, 0, 0, 1, 4'd5, 0, 4'd8);
    op("R7", 0, 0, 0, 0, 1, 1, 1, 4'd4, 1, 4'd6);
    op("R8", 0, 0, 0, 0, 0, 0, 0, 4'd8, 1, 4'd4);

    // R10: unused addresses read zero, writes ignored
    op("R10", 1, 0, 4'd12, 16'hFFFF, 0, 0, 0, 4'd12, 1, 4'd7);
    op("R10", 1, 1, 4'd7, 16'hFFFF, 0, 0, 1, 4'd15, 0, 4'd9);
    for (int k = 0; k < 9; k++)
      op("R10", 0, 0, 0, 0, 0, 0, 0, 4'(k), 1, 4'(k % 7));

    // R9: reset with alternate banks active returns to main, SP reloaded
    op("R9", 0, 0, 0, 0, 1, 1, 0, 4'd0, 0, 4'd6);
    do_reset();
    op("R9", 0, 0, 0, 0, 0, 0, 1, 4'd4, 0, 4'd0);
    op("R9", 0, 0, 0, 0, 0, 0, 1, 4'd3, 1, 4'd5);

    // constrained random mix
    for (int n = 0; n < N_RANDOM; n++) begin
      op("R1", ($urandom % 3) != 0, $urandom % 2, 4'($urandom % 16), 16'($urandom),
         ($urandom % 6) == 0, ($urandom % 6) == 0,
         $urandom % 2, 4'($urandom % 16), $urandom % 2, 4'($urandom % 16));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule